// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen architectural registers of a small processor core and maps each logical index onto one of twenty-seven physical storage words. The processor mode selects the mapping. Low registers are common to every mode. A middle group is replaced by a private set only during fast-interrupt mode. The top two general registers get a private copy in each of the four modes. The last logical register is a single shared word that packs the program counter, the condition flags, the two interrupt masks and the mode.

The mode the bank mapping uses is not a separate input. It comes from the two low bits of the packed status word, and it is also driven out for neighbouring logic. Two independent combinational read ports and one clocked write port serve the datapath. A write to the status word made from the unprivileged mode can only change the flags and the program counter.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register reads zero, and logical register 15 reads 32'h0C00_0003: supervisor mode, with both interrupt masks set.
- R2: Logical registers 0 to 7 reach the same storage in every mode. A value written in one mode is read back in any other mode.
- R3: Logical registers 8 to 12 use a private set of five words when the mode is 2'b01 (fast interrupt). In modes 2'b00, 2'b10 and 2'b11 they share one common set.
- R4: Logical registers 13 and 14 have four copies each, one per mode (2'b00 user, 2'b01 fast interrupt, 2'b10 interrupt, 2'b11 supervisor). A write in one mode is never seen in another mode.
- R5: Logical register 15 is one word shared by all modes. Its layout is: bits 31..28 are the flags N, Z, C, V; bit 27 is the interrupt mask; bit 26 is the fast-interrupt mask; bits 25..2 are the word program counter; bits 1..0 are the mode.
- R6: A write to register 15 while the mode is 2'b00 updates bits 31..28 and 25..2 only. Bits 27, 26, 1 and 0 keep their old values.
- R7: A write to register 15 in any privileged mode replaces the whole word. The new mode appears on `mode_o` and takes over the bank mapping from the next cycle on.
- R8: Reads are combinational. A write lands on the rising edge, in the copy selected by the mode in force during the write cycle, so a same-cycle read of the target still returns the old value.
- R9: While `wr_en` is low, no register changes, whatever is on `wr_idx` and `wr_data`. Both read ports resolve any index at the same time, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| mode_o | output | 2 | Current mode, taken from status word bits 1..0 |

## Verification
A wrong bank decode shows up on a read port in the same cycle as the lookup: the port returns another mode's copy. The bench therefore fills each mode with a distinct value per register, comes back to the mode later and reads everything again. A corrupted status word shows on `mode_o` one cycle after the faulty write, and it changes the mapping of registers 8 to 14 from that point. A write dropped into the wrong copy goes unseen until the victim mode is read again, which is why the bench reads every register after every mode change.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int XLEN       = 32;
  localparam int LOG_REGS   = 16;
  localparam int IDX_W      = $clog2(LOG_REGS);
  localparam int SHARED_LOW = 8;
  localparam int FIQ_SHADOW = 5;
  localparam int NUM_MODES  = 4;
  localparam int PER_MODE   = 2;
  localparam int NUM_SLOTS  = SHARED_LOW + 2 * FIQ_SHADOW + NUM_MODES * PER_MODE;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int HIGH_FIRST = SHARED_LOW + FIQ_SHADOW;
  localparam int PRIV_BASE  = SHARED_LOW + 2 * FIQ_SHADOW;
  localparam int PC_IDX     = LOG_REGS - 1;

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } cpu_mode_e;

  // bits that only a privileged write may change: masks and mode
  localparam logic [XLEN-1:0] CTRL_MASK = 32'h0C00_0003;
  localparam logic [XLEN-1:0] R15_RESET = 32'h0C00_0003;

  // storage order: shared low, common 8..12, fast-interrupt 8..12, then per-mode pairs
  function automatic logic [SLOT_W-1:0] slot_of(cpu_mode_e m, logic [IDX_W-1:0] idx);
    int ii;
    int s;
    ii = int'(idx);
    if (ii < SHARED_LOW)
      s = ii;
    else if (ii < HIGH_FIRST)
      s = (m == MODE_FIQ) ? ii + FIQ_SHADOW : ii;
    else
      s = PRIV_BASE + PER_MODE * int'(m) + (ii - HIGH_FIRST);
    return SLOT_W'(s);
  endfunction

  function automatic logic [XLEN-1:0] r15_merge(logic [XLEN-1:0] old_w,
                                                 logic [XLEN-1:0] new_w,
                                                 logic priv);
    return priv ? new_w : ((new_w & ~CTRL_MASK) | (old_w & CTRL_MASK));
  endfunction
endpackage

// File: rtl/bank_map.sv
module bank_map
  import regbank_pkg::*;
(
  input  cpu_mode_e         mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot,
  output logic              is_pc
);
  always_comb begin
    is_pc = (int'(idx) == PC_IDX);
    slot  = is_pc ? '0 : slot_of(mode, idx);
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import regbank_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [SLOT_W-1:0]            wslot,
  input  logic [XLEN-1:0]              wdata,
  input  logic [NRD-1:0][SLOT_W-1:0]   rslot,
  output logic [NRD-1:0][XLEN-1:0]     rdata
);
  logic [NUM_SLOTS-1:0][XLEN-1:0] bank_q;
  logic [NUM_SLOTS-1:0]           wen_vec;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign wen_vec[s] = we && (int'(wslot) == s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_q[s] <= '0;
      else if (wen_vec[s]) bank_q[s] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (int'(rslot[p]) < NUM_SLOTS) ? bank_q[rslot[p]] : '0;
  end

  // R8: a write lands in at most one physical word
  p_one_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wen_vec));

  // R9: no write enable, no change anywhere in the store
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bank_q));
endmodule

// File: rtl/psr_word.sv
module psr_word
  import regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] word_q,
  output cpu_mode_e       mode
);
  logic            priv_w;
  logic [XLEN-1:0] next_w;

  assign mode   = cpu_mode_e'(word_q[1:0]);
  assign priv_w = (mode != MODE_USR);
  assign next_w = r15_merge(word_q, wdata, priv_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= R15_RESET;
    else if (we) word_q <= next_w;
  end

  // R6: an unprivileged write keeps the masks and the mode
  p_user_ctrl_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && mode == MODE_USR) |=> ((word_q & CTRL_MASK) == ($past(word_q) & CTRL_MASK)));

  // R7: a privileged write replaces every bit
  p_priv_full_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && mode != MODE_USR) |=> (word_q == $past(wdata)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       rd_a_idx,
  output logic [31:0]      rd_a_data,
  input  logic [3:0]       rd_b_idx,
  output logic [31:0]      rd_b_data,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [31:0]      wr_data,
  output logic [1:0]       mode_o
);
  localparam int NRD = 2;

  cpu_mode_e                   cur_mode;
  logic [XLEN-1:0]             r15_q;
  logic [NRD:0][IDX_W-1:0]     map_idx;
  logic [NRD:0][SLOT_W-1:0]    map_slot;
  logic [NRD:0]                map_pc;
  logic [NRD-1:0][SLOT_W-1:0]  rd_slot;
  logic [NRD-1:0][XLEN-1:0]    gpr_rd;
  logic [NRD-1:0][XLEN-1:0]    port_out;
  logic                        gpr_we;
  logic                        psr_we;

  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  // index NRD is the write port, the rest are read ports
  for (genvar p = 0; p <= NRD; p++) begin : g_map
    bank_map u_map (
      .mode (cur_mode),
      .idx  (map_idx[p]),
      .slot (map_slot[p]),
      .is_pc(map_pc[p])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    assign rd_slot[p]  = map_slot[p];
    assign port_out[p] = map_pc[p] ? r15_q : gpr_rd[p];
  end

  assign gpr_we = wr_en && !map_pc[NRD];
  assign psr_we = wr_en &&  map_pc[NRD];

  gpr_store #(.NRD(NRD)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (gpr_we),
    .wslot(map_slot[NRD]),
    .wdata(wr_data),
    .rslot(rd_slot),
    .rdata(gpr_rd)
  );

  psr_word u_psr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (psr_we),
    .wdata (wr_data),
    .word_q(r15_q),
    .mode  (cur_mode)
  );

  assign rd_a_data = port_out[0];
  assign rd_b_data = port_out[1];
  assign mode_o    = cur_mode;

  // R8: a general write is read back on port A next cycle if index and mode match
  p_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) != PC_IDX) |=>
      (rd_a_idx != $past(wr_idx) || mode_o != $past(mode_o) || rd_a_data == $past(wr_data)));

  // R7: the mode output only moves after a write to register 15
  p_mode_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !psr_we |=> $stable(mode_o));
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0;
  logic [31:0] rd_a_data;
  logic [3:0]  rd_b_idx = '0;
  logic [31:0] rd_b_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  mode_o;

  int n_checks = 0;
  int n_errors = 0;

  logic [31:0] m_slot [0:25];
  logic [31:0] m_r15;

  always #10 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mode_o(mode_o)
  );

  // model storage: 0..7 shared, 8..12 common high, 13..17 fast-interrupt high, 18+ per-mode pairs
  function automatic int bslot(int m, int r);
    if (r < 8) return r;
    if (r < 13) return (m == 1) ? r + 5 : r;
    return 18 + 2 * m + (r - 13);
  endfunction

  function automatic logic [31:0] expect_rd(int r);
    if (r == 15) return m_r15;
    return m_slot[bslot(int'(m_r15[1:0]), r)];
  endfunction

  function automatic string tag_of(int r);
    if (r < 8)  return "R2";
    if (r < 13) return "R3";
    if (r < 15) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(int idx, logic [31:0] d);
    logic [31:0] ctrl;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx == 15) begin
      ctrl = 32'h0C00_0003;
      if (m_r15[1:0] == 2'b00) m_r15 = (d & ~ctrl) | (m_r15 & ctrl);
      else m_r15 = d;
    end else begin
      m_slot[bslot(int'(m_r15[1:0]), idx)] = d;
    end
  endtask

  task automatic set_mode(int m);
    do_write(15, {4'h9, 2'b11, 24'h001230 + 24'(m), 2'(m)});
  endtask

  task automatic read_all();
    for (int r = 0; r < 16; r++) begin
      rd_a_idx = 4'(r);
      rd_b_idx = 4'(15 - r);
      #1;
      check({tag_of(r), " port A"}, rd_a_data, expect_rd(r));
      check({tag_of(15 - r), " port B (R9)"}, rd_b_data, expect_rd(15 - r));
    end
    check("R7 mode_o", {30'd0, mode_o}, {30'd0, m_r15[1:0]});
  endtask

  function automatic logic [31:0] tagval(int m, int r, int pass);
    return {8'hA0 + 8'(m), 8'(r), 8'(pass), 8'h5C};
  endfunction

  initial begin
    for (int i = 0; i < 26; i++) m_slot[i] = '0;
    m_r15 = 32'h0C00_0003;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset contents, supervisor mode with masks set
    for (int r = 0; r < 15; r++) begin
      rd_a_idx = 4'(r); #1;
      check("R1 reset zero", rd_a_data, 32'h0);
    end
    rd_b_idx = 4'd15; #1;
    check("R1 reset r15", rd_b_data, 32'h0C00_0003);
    check("R1 reset mode", {30'd0, mode_o}, 32'd3);

    // fill every privileged mode with distinct values
    for (int k = 0; k < 3; k++) begin
      int m;
      m = 3 - k;
      set_mode(m);
      for (int r = 0; r < 15; r++) do_write(r, tagval(m, r, 1));
      read_all();
    end
    // come back to each mode: shadows must have survived (R3, R4)
    for (int k = 0; k < 3; k++) begin
      set_mode(3 - k);
      read_all();
    end

    // R8: same-cycle read of the write target still returns the old value
    set_mode(1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'hDEAD_0009;
    rd_a_idx = 4'd9; #1;
    check("R8 old value before edge", rd_a_data, m_slot[bslot(1, 9)]);
    @(negedge clk);
    wr_en = 1'b0;
    m_slot[bslot(1, 9)] = 32'hDEAD_0009;
    #1;
    check("R8 new value after edge", rd_a_data, 32'hDEAD_0009);

    // R9: data presented without enable changes nothing
    @(negedge clk);
    wr_idx = 4'd3; wr_data = 32'h1111_2222;
    @(negedge clk);
    wr_idx = 4'd15; wr_data = 32'h0000_0000;
    @(negedge clk);
    read_all();

    // R7: privileged full write, masks cleared, mode to interrupt
    do_write(15, 32'hF3FF_FFFE);
    rd_a_idx = 4'd15; #1;
    check("R7 full r15 write", rd_a_data, 32'hF3FF_FFFE);
    check("R7 mode follows", {30'd0, mode_o}, 32'd2);
    read_all();

    // unprivileged mode: own copies of 13/14 start at zero
    set_mode(0);
    read_all();
    for (int r = 0; r < 15; r++) do_write(r, tagval(0, r, 2));
    read_all();

    // R6: unprivileged r15 write keeps masks and mode
    do_write(15, 32'h0000_0000);
    rd_a_idx = 4'd15; #1;
    check("R6 ctrl kept", rd_a_data, 32'h0C00_0000);
    do_write(15, 32'hF3FF_FFFE);
    rd_a_idx = 4'd15; #1;
    check("R6 flags and pc written", rd_a_data, 32'hFFFF_FFFC);
    check("R6 mode stays user", {30'd0, mode_o}, 32'd0);
    read_all();

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule